// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs whole NAND flash operations on behalf of a host. The host picks an operation (page read, page program or block erase), supplies a row number and a column, and pulses a start input. The sequencer then drives the chip enable, the command and address latch selects, and the write and read strobes of an 8-bit shared I/O bus. It issues the command, address and data phases that the operation needs and waits through the device busy period. For erase and program it finishes by reading back the device status byte.

Page bytes to be programmed arrive on a valid/ready input stream. Page bytes that are read leave on a valid/ready output stream. On the input stream the sequencer raises `wr_ready` only when it can start a write strobe, so a byte moves on a cycle with both `wr_valid` and `wr_ready` high. A source that holds `wr_valid` low simply stalls the bus between data strobes. On the output stream each byte stays on `rd_data` with `rd_valid` high until `rd_ready` is seen. No further read strobe is issued while a byte is waiting, so a slow sink stalls the bus and no byte is lost.

Strobe widths, the gap after a confirm command and the busy timeout come from count inputs that the host sets. When the operation ends, `done` pulses once and `pass` carries the result.

Top module: `nfc_seq`

## Requirements
- R1: Each bus cycle has one type, set by the latch selects: command is `nf_cle`=1, `nf_ale`=0; address is `nf_ale`=1, `nf_cle`=0; data is both 0. Both high never occurs, and the write and read strobes are never low together.
- R2: `nf_ce_n` is high whenever the block is idle. It goes low when the first command begins and stays low through every busy wait until the operation ends. No strobe goes low while `nf_ce_n` is high.
- R3: Erase (`op`=2) writes command 0x60, then only the row address bytes, then confirm 0xD0. After ready it writes 0x70 and reads one status byte.
- R4: Program (`op`=1) writes command 0x80 and all address bytes, then PAGE_BYTES data bytes in stream order. It then writes confirm 0x10, waits for ready, writes 0x70 and reads one status byte.
- R5: Read (`op`=0) writes command 0x00, all address bytes and confirm 0x30. After ready it issues PAGE_BYTES read strobes and delivers the bytes in order on the output stream. The block never drives the bus while the read strobe is low.
- R6: The address word is {row, column} with a 12-bit column. The column goes out first, low byte first: bits 7..0, then bits 11..8 zero-extended. The row follows, low byte first, in 8-bit pieces, and the last piece is zero-extended (three row bytes for a 17-bit row).
- R7: For erase and program, `pass` is 1 exactly when the status byte read back is 0xE0. A read that sees ready reports `pass`=1.
- R8: After a confirm command and the gap count, the sequencer waits for the synchronized ready/busy line to go low and then high. If that has not happened within the timeout count of waiting cycles, it ends with `pass`=0 and issues no further bus cycles.
- R9: `start` is taken only when the block is idle and `op` is 0, 1 or 2. A start while busy, or with `op`=3, has no effect.
- R10: `busy` is high from the cycle after an accepted start until the cycle after `done`. `done` is high for exactly one cycle, and `pass` is valid while `done` is high.
- R11: A write strobe for page data starts only after a stream handshake. The next read strobe starts only after the previous byte has been taken, and `rd_data` stays stable while `rd_valid` waits for `rd_ready`.
- R12: Every write or read strobe is low for exactly `cfg_low` clock cycles. A value of 0 in any count input (`cfg_low`, `cfg_high`, `cfg_gap`, `cfg_tmo`) acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| op | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 rejected |
| req_block | input | BLOCK_W | Row number, upper part of the address word |
| req_col | input | COL_W | Column, lower part of the address word |
| cfg_low | input | TW | Strobe low width in cycles |
| cfg_high | input | TW | Strobe high width in cycles |
| cfg_gap | input | TW | Cycles between the end of a confirm command and the first ready/busy check |
| cfg_tmo | input | TMO_W | Limit on cycles spent waiting for ready/busy |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Sequencer can take a program data byte |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte available |
| rd_ready | input | 1 | Sink takes the read data byte |
| rd_data | output | 8 | Read data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Result, valid with done |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cle | output | 1 | Command latch select |
| nf_ale | output | 1 | Address latch select |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus value driven to the device |
| nf_dq_oe | output | 1 | Bus output enable for an external tristate buffer |
| nf_dq_i | input | 8 | Bus value from the device |
| nf_rb_n | input | 1 | Device ready/busy, low while busy |

## Verification
Erase is run twice, with good status 0xE0 and with 0xC0, so that a status compare reduced to a subset of bits is caught. Program is run with a column whose two column bytes differ and with a row whose top bit is set, so that byte order and zero extension show in every address phase. Its input stream has gaps, to show that stalls neither skip nor repeat a byte. Read runs with a stuttering `rd_ready` and with a distinct value in every byte, which separates lost, repeated and reordered bytes. Further runs cover a ready line that never goes busy (the timeout path), zero-valued counts, a start with the rejected code and a start during an operation.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    OPC_READ  = 2'd0,
    OPC_PROG  = 2'd1,
    OPC_ERASE = 2'd2,
    OPC_RSVD  = 2'd3
  } nfc_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_GAP,
    S_WLO, S_WHI, S_SCMD, S_SRD, S_RDATA, S_FIN
  } nfc_state_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_LOW, PH_HIGH
  } nfc_phase_e;

  localparam logic [7:0] CMD_READ_SETUP  = 8'h00;
  localparam logic [7:0] CMD_READ_GO     = 8'h30;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO     = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] STATUS_GOOD     = 8'hE0;

endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] sr;

  // Resets to "ready" so a fresh operation never sees a stale busy level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d_in};
  end

  assign q_out = sr[STAGES-1];
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe import nfc_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rd,
  input  logic [CW-1:0] lo_cyc,
  input  logic [CW-1:0] hi_cyc,
  output logic          we_n,
  output logic          re_n,
  output logic          smp,
  output logic          fin
);
  nfc_phase_e    ph;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic [CW-1:0] lo_m1, hi_m1;

  assign lo_m1 = (lo_cyc == '0) ? '0 : lo_cyc - 1'b1;
  assign hi_m1 = (hi_cyc == '0) ? '0 : hi_cyc - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      rd_q <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (go) begin
          ph   <= PH_LOW;
          cnt  <= lo_m1;
          rd_q <= rd;
        end
        PH_LOW: if (cnt == '0) begin
          ph  <= PH_HIGH;
          cnt <= hi_m1;
        end else cnt <= cnt - 1'b1;
        PH_HIGH: if (cnt == '0) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign we_n = !(ph == PH_LOW && !rd_q);
  assign re_n = !(ph == PH_LOW && rd_q);
  // Read data is captured on the last low cycle, while the device still drives it
  assign smp  = (ph == PH_LOW) && (cnt == '0) && rd_q;
  assign fin  = (ph == PH_HIGH) && (cnt == '0);
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq import nfc_pkg::*; #(
  parameter int BLOCK_W    = 17,
  parameter int COL_W      = 12,
  parameter int PAGE_BYTES = 2112,
  parameter int TW         = 8,
  parameter int TMO_W      = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         op,
  input  logic [BLOCK_W-1:0] req_block,
  input  logic [COL_W-1:0]   req_col,
  input  logic [TW-1:0]      cfg_low,
  input  logic [TW-1:0]      cfg_high,
  input  logic [TW-1:0]      cfg_gap,
  input  logic [TMO_W-1:0]   cfg_tmo,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [7:0]         wr_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [7:0]         rd_data,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic               nf_ce_n,
  output logic               nf_cle,
  output logic               nf_ale,
  output logic               nf_we_n,
  output logic               nf_re_n,
  output logic [7:0]         nf_dq_o,
  output logic               nf_dq_oe,
  input  logic [7:0]         nf_dq_i,
  input  logic               nf_rb_n
);
  localparam int COL_BYTES = (COL_W + 7) / 8;
  localparam int ROW_BYTES = (BLOCK_W + 7) / 8;
  localparam int NAB       = COL_BYTES + ROW_BYTES;
  localparam int AI_W      = $clog2(NAB);
  localparam int BC_W      = $clog2(PAGE_BYTES + 1);
  localparam logic [BC_W-1:0] LAST_CNT = BC_W'(PAGE_BYTES);

  nfc_state_e         st;
  nfc_op_e            op_q;
  logic [BLOCK_W-1:0] blk_q;
  logic [COL_W-1:0]   col_q;
  logic [AI_W-1:0]    idx;
  logic [BC_W-1:0]    bcnt;
  logic [TMO_W-1:0]   tcnt;
  logic               cyc_act, go_q, rd_go;
  logic               cle_q, ale_q, oe_q, rvld_q, pass_q;
  logic [7:0]         dq_q, rdat_q;
  logic               rb_s, ph_smp, ph_fin;

  nfc_sync #(.STAGES(2)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d_in(nf_rb_n), .q_out(rb_s)
  );

  nfc_strobe #(.CW(TW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(go_q), .rd(rd_go),
    .lo_cyc(cfg_low), .hi_cyc(cfg_high),
    .we_n(nf_we_n), .re_n(nf_re_n), .smp(ph_smp), .fin(ph_fin)
  );

  // Address bytes: column pieces first, then row pieces, each low byte first
  logic [COL_BYTES*8-1:0] col_pad;
  logic [ROW_BYTES*8-1:0] row_pad;
  logic [7:0]             ab [NAB];
  assign col_pad = (COL_BYTES*8)'(col_q);
  assign row_pad = (ROW_BYTES*8)'(blk_q);

  for (genvar g = 0; g < NAB; g++) begin : g_ab
    if (g < COL_BYTES) begin : g_col
      assign ab[g] = col_pad[g*8 +: 8];
    end else begin : g_row
      assign ab[g] = row_pad[(g-COL_BYTES)*8 +: 8];
    end
  end

  logic [TW-1:0]    gap_m1;
  logic [TMO_W-1:0] tmo_m1;
  assign gap_m1 = (cfg_gap == '0) ? '0 : cfg_gap - 1'b1;
  assign tmo_m1 = (cfg_tmo == '0) ? '0 : cfg_tmo - 1'b1;

  logic [7:0] cmd_setup, cmd_go;
  always_comb begin
    unique case (op_q)
      OPC_PROG:  begin cmd_setup = CMD_PROG_SETUP;  cmd_go = CMD_PROG_GO;  end
      OPC_ERASE: begin cmd_setup = CMD_ERASE_SETUP; cmd_go = CMD_ERASE_GO; end
      default:   begin cmd_setup = CMD_READ_SETUP;  cmd_go = CMD_READ_GO;  end
    endcase
  end

  // Which bus cycle the current state wants to start next
  logic       l_en, l_cle, l_ale, l_rd, launch;
  logic [7:0] l_dq;
  assign wr_ready = (st == S_WDATA) && !cyc_act && (bcnt != LAST_CNT);

  always_comb begin
    l_en = 1'b0; l_cle = 1'b0; l_ale = 1'b0; l_rd = 1'b0; l_dq = 8'h00;
    unique case (st)
      S_CMD1:  begin l_en = 1'b1; l_cle = 1'b1; l_dq = cmd_setup; end
      S_ADDR:  begin l_en = 1'b1; l_ale = 1'b1; l_dq = ab[idx]; end
      S_WDATA: begin l_en = wr_valid && wr_ready; l_dq = wr_data; end
      S_CMD2:  begin l_en = 1'b1; l_cle = 1'b1; l_dq = cmd_go; end
      S_SCMD:  begin l_en = 1'b1; l_cle = 1'b1; l_dq = CMD_STATUS; end
      S_SRD:   begin l_en = 1'b1; l_rd = 1'b1; end
      S_RDATA: begin l_en = !rvld_q && (bcnt != LAST_CNT); l_rd = 1'b1; end
      default: ;
    endcase
    launch = l_en && !cyc_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OPC_READ; blk_q <= '0; col_q <= '0;
      idx <= '0; bcnt <= '0; tcnt <= '0;
      cyc_act <= 1'b0; go_q <= 1'b0; rd_go <= 1'b0;
      cle_q <= 1'b0; ale_q <= 1'b0; oe_q <= 1'b0; dq_q <= '0;
      rdat_q <= '0; rvld_q <= 1'b0; pass_q <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (launch) begin
        go_q <= 1'b1; cyc_act <= 1'b1; rd_go <= l_rd;
        cle_q <= l_cle; ale_q <= l_ale; dq_q <= l_dq; oe_q <= !l_rd;
      end
      if (ph_fin) begin
        cyc_act <= 1'b0; cle_q <= 1'b0; ale_q <= 1'b0; oe_q <= 1'b0;
      end
      if (rvld_q && rd_ready) rvld_q <= 1'b0;

      unique case (st)
        S_IDLE: if (start && nfc_op_e'(op) != OPC_RSVD) begin
          st     <= S_CMD1;
          op_q   <= nfc_op_e'(op);
          blk_q  <= req_block;
          col_q  <= req_col;
          idx    <= (nfc_op_e'(op) == OPC_ERASE) ? AI_W'(COL_BYTES) : '0;
          pass_q <= 1'b0;
        end
        S_CMD1: if (ph_fin) st <= S_ADDR;
        S_ADDR: if (ph_fin) begin
          if (idx == AI_W'(NAB - 1)) begin
            st   <= (op_q == OPC_PROG) ? S_WDATA : S_CMD2;
            bcnt <= '0;
          end else idx <= idx + 1'b1;
        end
        S_WDATA: begin
          if (ph_fin) bcnt <= bcnt + 1'b1;
          if (bcnt == LAST_CNT) st <= S_CMD2;
        end
        S_CMD2: if (ph_fin) begin st <= S_GAP; tcnt <= '0; end
        S_GAP: begin
          if (tcnt == TMO_W'(gap_m1)) begin st <= S_WLO; tcnt <= '0; end
          else tcnt <= tcnt + 1'b1;
        end
        S_WLO, S_WHI: begin
          tcnt <= tcnt + 1'b1;
          if (st == S_WLO && !rb_s) st <= S_WHI;
          else if (st == S_WHI && rb_s) begin
            if (op_q == OPC_READ) begin
              st <= S_RDATA; bcnt <= '0; pass_q <= 1'b1;
            end else st <= S_SCMD;
          end else if (tcnt == tmo_m1) begin
            st <= S_FIN; pass_q <= 1'b0;
          end
        end
        S_SCMD: if (ph_fin) st <= S_SRD;
        S_SRD: begin
          if (ph_smp) pass_q <= (nf_dq_i == STATUS_GOOD);
          if (ph_fin) st <= S_FIN;
        end
        S_RDATA: begin
          if (ph_smp) begin rdat_q <= nf_dq_i; rvld_q <= 1'b1; end
          if (ph_fin) bcnt <= bcnt + 1'b1;
          if (bcnt == LAST_CNT && !rvld_q) st <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign pass     = pass_q;
  assign nf_ce_n  = (st == S_IDLE) || (st == S_FIN);
  assign nf_cle   = cle_q;
  assign nf_ale   = ale_q;
  assign nf_dq_o  = dq_q;
  assign nf_dq_oe = oe_q;
  assign rd_valid = rvld_q;
  assign rd_data  = rdat_q;
endmodule

// File: rtl/nfc_seq_chk.sv
module nfc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       nf_ce_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_dq_oe,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  AST_NO_RESERVED_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale)); // R1
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n)); // R1
  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R2
  AST_IDLE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> nf_ce_n); // R2
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_dq_oe); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10
  AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done)); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R11
endmodule

bind nfc_seq nfc_seq_chk i_nfc_seq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_oe(nf_dq_oe),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/test_nfc_seq.sv
module test_nfc_seq;
  localparam int CLK_NS = 10;
  localparam int PB = 6;
  localparam int BW = 17;
  localparam int CW = 12;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst_n, start;
  logic [1:0] op;
  logic [BW-1:0] req_block;
  logic [CW-1:0] req_col;
  logic [7:0] cfg_low, cfg_high, cfg_gap;
  logic [19:0] cfg_tmo;
  logic wr_valid = 1'b0, wr_ready, rd_valid, rd_ready = 1'b0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic busy, done, pass;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_rb_n;
  logic [7:0] nf_dq_o, nf_dq_i;

  nfc_seq #(.BLOCK_W(BW), .COL_W(CW), .PAGE_BYTES(PB)) i_nfc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .req_block(req_block), .req_col(req_col),
    .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_gap(cfg_gap), .cfg_tmo(cfg_tmo),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .pass(pass),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb_n(nf_rb_n)
  );

  int n_chk = 0, n_fail = 0;
  bit ended = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // Scoreboard queues: bus cycles latched by write strobes, and read stream bytes
  logic [9:0] exp_q[$];
  logic [7:0] rexp_q[$];

  function automatic void push_cmd(input logic [7:0] b);  exp_q.push_back({2'b10, b}); endfunction
  function automatic void push_addr(input logic [7:0] b); exp_q.push_back({2'b01, b}); endfunction
  function automatic void push_dat(input logic [7:0] b);  exp_q.push_back({2'b00, b}); endfunction

  function automatic void push_rows(input logic [BW-1:0] b);
    push_addr(b[7:0]); push_addr(b[15:8]); push_addr({7'b0, b[16]});
  endfunction
  function automatic void push_cols(input logic [CW-1:0] c);
    push_addr(c[7:0]); push_addr({4'b0, c[11:8]});
  endfunction

  // Device model
  logic [7:0] stat_val = 8'hE0;
  bit stat_mode = 1'b0, stuck = 1'b0;
  int re_cnt = 0, re_base = 0, kick = 0, kseen = 0, btimer = 0;

  assign nf_dq_i = stat_mode ? stat_val : (8'h30 ^ 8'(re_cnt - re_base));
  assign nf_rb_n = (btimer == 0) || (btimer > 20);

  always @(posedge nf_we_n) begin
    if (rst_n === 1'b1 && nf_ce_n === 1'b0) begin
      logic [9:0] got, e;
      got = {nf_cle, nf_ale, nf_dq_o};
      chk(!(nf_cle && nf_ale), "R1", "reserved cycle type", int'(got), 0);
      if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected bus cycle", int'(got), 0);
      else begin
        e = exp_q.pop_front();
        chk(got == e, "R3/R4/R5/R6", "bus cycle {cle,ale,dq}", int'(got), int'(e));
      end
      if (nf_cle) begin
        if (nf_dq_o == 8'h70) stat_mode = 1'b1;
        if (nf_dq_o == 8'h00) begin stat_mode = 1'b0; re_base = re_cnt; end
        if (nf_dq_o == 8'h10 || nf_dq_o == 8'h30 || nf_dq_o == 8'hD0) kick++;
      end
    end
  end

  always @(posedge nf_re_n)
    if (rst_n === 1'b1 && nf_ce_n === 1'b0) re_cnt++;

  always @(posedge clk) begin
    if (kick != kseen) begin
      kseen <= kick;
      if (!stuck) btimer <= 26;
    end else if (btimer > 0) btimer <= btimer - 1;
  end

  // Stream driver and monitor, plus strobe width measurement, all at the falling edge
  int wr_ptr = 0, wr_n = 0, cyc = 0, lo_run = 0;
  always @(negedge clk) begin
    cyc++;
    wr_data  = 8'hC0 + 8'(wr_ptr);
    wr_valid = (wr_ptr < wr_n) && (cyc % 3 != 0);
    rd_ready = (cyc % 4 != 1);
    #1;
    if (wr_valid && wr_ready) wr_ptr++;
    if (rd_valid && rd_ready) begin
      if (rexp_q.size() == 0) chk(1'b0, "R5", "unexpected read byte", int'(rd_data), 0);
      else begin
        logic [7:0] e;
        e = rexp_q.pop_front();
        chk(rd_data == e, "R5", "read stream byte", int'(rd_data), int'(e));
      end
    end
    if (rst_n === 1'b1 && (nf_we_n === 1'b0 || nf_re_n === 1'b0)) lo_run++;
    else if (lo_run > 0) begin
      int eff;
      eff = (cfg_low == 0) ? 1 : int'(cfg_low);
      chk(lo_run == eff, "R12", "strobe low width", lo_run, eff);
      lo_run = 0;
    end
  end

  task automatic start_op(input logic [1:0] o, input logic [BW-1:0] b, input logic [CW-1:0] c);
    @(negedge clk);
    op = o; req_block = b; req_col = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input bit exp_pass, input string rq);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, "R10", "done pulse seen", int'(seen), 1);
    if (seen) begin
      chk(pass == exp_pass, rq, "pass result", int'(pass), int'(exp_pass));
      chk(busy == 1'b1, "R10", "busy with done", int'(busy), 1);
      @(negedge clk);
      chk(!done && !busy, "R10", "done one cycle then idle", int'({done, busy}), 0);
      chk(nf_ce_n == 1'b1, "R2", "ce high after end", int'(nf_ce_n), 1);
    end
    chk(exp_q.size() == 0, rq, "missing bus cycles", exp_q.size(), 0);
    chk(rexp_q.size() == 0, rq, "missing read bytes", rexp_q.size(), 0);
  endtask

  task automatic do_erase(input logic [BW-1:0] b, input logic [7:0] st, input bit exp_pass);
    stat_val = st;
    push_cmd(8'h60); push_rows(b); push_cmd(8'hD0);
    if (!stuck) push_cmd(8'h70);
    start_op(2'd2, b, 12'h0);
    wait_done(exp_pass, stuck ? "R8" : "R3/R7");
  endtask

  task automatic do_prog(input logic [BW-1:0] b, input logic [CW-1:0] c);
    stat_val = 8'hE0;
    push_cmd(8'h80); push_cols(c); push_rows(b);
    for (int i = 0; i < PB; i++) push_dat(8'hC0 + 8'(i));
    push_cmd(8'h10); push_cmd(8'h70);
    wr_ptr = 0; wr_n = PB;
    start_op(2'd1, b, c);
    wait_done(1'b1, "R4/R11");
    wr_n = 0; wr_ptr = 0;
  endtask

  task automatic do_read(input logic [BW-1:0] b, input logic [CW-1:0] c);
    push_cmd(8'h00); push_cols(c); push_rows(b); push_cmd(8'h30);
    for (int i = 0; i < PB; i++) rexp_q.push_back(8'h30 ^ 8'(i));
    start_op(2'd0, b, c);
    wait_done(1'b1, "R5/R7");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'd0; req_block = '0; req_col = '0;
    cfg_low = 8'd2; cfg_high = 8'd1; cfg_gap = 8'd2; cfg_tmo = 20'd60;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: R2 R10
    chk(!busy && !done, "R10", "idle after reset", int'({busy, done}), 0);
    chk(nf_ce_n && nf_we_n && nf_re_n && !nf_dq_oe, "R2", "bus quiet after reset",
        int'({nf_ce_n, nf_we_n, nf_re_n, nf_dq_oe}), 4'b1110);

    do_erase(17'h1A5C3, 8'hE0, 1'b1);   // R3 R6 R7
    do_erase(17'h00042, 8'hC0, 1'b0);   // R7 failing status
    do_prog(17'h10102, 12'hABC);        // R4 R6 R11
    do_read(17'h00005, 12'h7FF);        // R5 R11

    // R12: zero counts act as one
    cfg_low = 8'd0; cfg_high = 8'd0; cfg_gap = 8'd0;
    do_prog(17'h0F00F, 12'h123);
    cfg_low = 8'd3; cfg_high = 8'd2; cfg_gap = 8'd1;
    do_read(17'h1FFFF, 12'hFFF);

    // R8: ready line never goes busy, so the wait times out
    stuck = 1'b1;
    do_erase(17'h00777, 8'hE0, 1'b0);
    stuck = 1'b0;

    // R9: rejected op code
    start_op(2'd3, 17'h1, 12'h1);
    repeat (5) @(negedge clk);
    chk(!busy && nf_ce_n, "R9", "op 3 ignored", int'({busy, nf_ce_n}), 1);

    // R9: start during an operation
    stat_val = 8'hE0;
    push_cmd(8'h60); push_rows(17'h00321); push_cmd(8'hD0); push_cmd(8'h70);
    start_op(2'd2, 17'h00321, 12'h0);
    repeat (4) @(negedge clk);
    op = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(1'b1, "R9");
    repeat (20) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R9", "busy start ignored", int'(busy), 0);

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule